// File: doc/BRIEF.md
# Pre-Trigger Sample History Delay

This block sits in the capture path of a 16-channel logic analyzer, between the sampling logic and the capture engine. It holds back the stream of valid-qualified samples by a programmable number of samples. When a trigger fires, the capture engine therefore receives samples that were taken before the trigger, in the same cycle as the trigger itself. The depth is read live from a 32-bit configuration word. Values above a build-time maximum are treated as that maximum.

A depth of zero turns the block into a plain wire from input to output. It also throws away the stored history, so the next nonzero depth starts from an empty store. Any change to the effective depth restarts the fill. Output valid then stays low until the new depth's worth of samples has been written.

The storage is a circular RAM with a single write pointer. The read address sits the effective depth behind the write pointer, and the RAM is read combinationally. A delayed sample therefore leaves the block in the same cycle that a new sample arrives.

Top module: `history_delay`

## Requirements
- R1: When the effective depth is 0, `out_valid` equals `in_valid` and `out_data` equals `in_data` in the same cycle, with no register in the path.
- R2: A cycle with depth 0 empties the history. On return to a nonzero depth D, `out_valid` is low for the first D valid input samples.
- R3: With effective depth D > 0, once the history is full, the output produced in the cycle of the k-th valid input sample (counted from the last restart) carries sample k−D, with `out_valid` high.
- R4: After a restart, `out_valid` is low for the first D valid samples and high from sample D onward.
- R5: The history advances only in cycles where `in_valid` is high. `out_valid` is never high in a cycle where `in_valid` is low, and this also holds after reset.
- R6: The effective depth is min(`depth_cfg`, MAX_DEPTH). This comparison uses all 32 bits, so a value such as 0x0001_0000 means MAX_DEPTH and not 0.
- R7: A direct change between two different nonzero effective depths restarts the fill, as described in R4. The change is applied in the cycle in which the new value is first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_cfg | input | CFG_W (32) | Requested history depth in samples |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | DATA_W (16) | Input sample |
| out_valid | output | 1 | Delayed sample qualifier |
| out_data | output | DATA_W (16) | Delayed sample |

## Verification
The bench sweeps every depth from 0 to two past the maximum. It also uses two large configuration words, one of which has all low bits clear, to separate correct clamping from truncation. Each depth is run twice: once with a sample on every cycle, and once with a gap in every third cycle. The gaps expose any design that advances on clock cycles rather than on valid samples. Two further scenarios handle restarts: a direct jump between two nonzero depths, and a fill, zero, refill sequence. Together they tell a real restart apart from pointer drift or stale history leaking through.

// File: rtl/history_delay.sv
`timescale 1ns/1ps
module history_delay #(
  parameter int DATA_W    = 16,
  parameter int CFG_W     = 32,
  parameter int MAX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  depth_cfg,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int AW = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;
  localparam int CW = $clog2(MAX_DEPTH + 1);

  logic [DATA_W-1:0] mem [MAX_DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     dep, dep_q, fill, fill_eff;
  logic [CW:0]       wr_ext, dep_ext, rd_full;
  logic              restart, bypass;

  assign dep      = (depth_cfg > CFG_W'(MAX_DEPTH)) ? CW'(MAX_DEPTH) : depth_cfg[CW-1:0];
  assign bypass   = (dep == '0);
  assign restart  = (dep != dep_q);
  assign fill_eff = restart ? '0 : fill;

  assign wr_ext  = (CW+1)'(wr_ptr);
  assign dep_ext = {1'b0, dep};
  assign rd_full = (wr_ext >= dep_ext) ? (wr_ext - dep_ext)
                                       : (wr_ext + (CW+1)'(MAX_DEPTH) - dep_ext);
  assign rd_ptr  = rd_full[AW-1:0];

  assign out_valid = in_valid && (bypass || (fill_eff >= dep));
  assign out_data  = bypass ? in_data : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (in_valid && !bypass) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dep_q  <= '0;
      fill   <= '0;
      wr_ptr <= '0;
    end else begin
      dep_q <= dep;
      if (bypass) begin
        fill   <= '0;
        wr_ptr <= '0;
      end else begin
        if (in_valid) begin
          fill   <= (fill_eff == CW'(MAX_DEPTH)) ? fill_eff : fill_eff + 1'b1;
          wr_ptr <= (wr_ptr == AW'(MAX_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        end else begin
          fill   <= fill_eff;
        end
      end
    end
  end
endmodule

// File: rtl/history_delay_chk.sv
`timescale 1ns/1ps
module history_delay_chk #(
  parameter int DATA_W    = 16,
  parameter int CFG_W     = 32,
  parameter int MAX_DEPTH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_W-1:0]  depth_cfg,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  localparam int CW = $clog2(MAX_DEPTH + 1);

  logic [CFG_W-1:0] lim, lim_q;
  logic [CW:0]      seen, seen_eff;
  assign lim      = (depth_cfg > CFG_W'(MAX_DEPTH)) ? CFG_W'(MAX_DEPTH) : depth_cfg;
  assign seen_eff = (lim != lim_q) ? '0 : seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q <= '0;
      seen  <= '0;
    end else begin
      lim_q <= lim;
      if (lim == '0)                                          seen <= '0;
      else if (in_valid && seen_eff != (CW+1)'(MAX_DEPTH))    seen <= seen_eff + 1'b1;
      else                                                    seen <= seen_eff;
    end
  end

  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_cfg == '0) |-> (out_valid == in_valid) && (out_data == in_data));

  p_zero_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(depth_cfg) == '0) && (depth_cfg != '0) |-> !out_valid);

  p_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (lim != '0) |-> (CFG_W'(seen_eff) >= lim));

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !out_valid);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lim != lim_q) && (lim != '0) |-> !out_valid);
endmodule

bind history_delay history_delay_chk #(
  .DATA_W(DATA_W), .CFG_W(CFG_W), .MAX_DEPTH(MAX_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .depth_cfg(depth_cfg), .in_valid(in_valid),
  .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/history_delay_tb.sv
`timescale 1ns/1ps
module history_delay_tb;
  localparam int MAXD = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] depth_cfg = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  history_delay #(.DATA_W(16), .CFG_W(32), .MAX_DEPTH(MAXD)) u_dut (
    .clk(clk), .rst_n(rst_n), .depth_cfg(depth_cfg), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  function automatic logic [15:0] pat(int seed, int k);
    return 16'((k * 37) + (seed * 251) + 5);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(logic [31:0] cfg, bit gaps, bit zero_first, string tag, int ncyc, int seed);
    int d;
    int k;
    bit v;
    d = (cfg > 32'(MAXD)) ? MAXD : int'(cfg);
    if (zero_first) begin
      @(negedge clk); depth_cfg = '0; in_valid = 1'b0;
    end
    k = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      depth_cfg = cfg;
      v = gaps ? ((c % 3) != 1) : 1'b1;
      in_valid = v;
      in_data = pat(seed, k);
      #1;
      if (!v) chk("R5 idle", 16'(out_valid), 16'(0));
      else if (d == 0) begin
        chk("R1 valid", 16'(out_valid), 16'(1));
        chk("R1 data", out_data, pat(seed, k));
      end else begin
        chk((k < d) ? tag : "R4", 16'(out_valid), 16'(k >= d));
        if (k >= d) chk((cfg > 32'(MAXD)) ? "R6" : "R3", out_data, pat(seed, k - d));
      end
      if (v) k++;
    end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R5 reset", 16'(out_valid), 16'(0));
    @(negedge clk); rst_n = 1'b1;
    for (int d = 0; d <= MAXD + 2; d++) begin
      run(32'(d), 1'b0, 1'b1, "R4", 3 * MAXD, d);
      run(32'(d), 1'b1, 1'b1, "R4", 3 * MAXD, d + 50);
    end
    run(32'hFFFF_FFFF, 1'b0, 1'b1, "R6", 3 * MAXD, 7);
    run(32'h0001_0000, 1'b1, 1'b1, "R6", 3 * MAXD, 9);
    run(32'd5, 1'b0, 1'b1, "R4", 12, 11);
    run(32'd3, 1'b0, 1'b0, "R7", 12, 12);
    run(32'd9, 1'b1, 1'b0, "R7", 24, 13);
    run(32'd4, 1'b0, 1'b1, "R4", 10, 14);
    run(32'd4, 1'b0, 1'b1, "R2", 12, 15);
    @(negedge clk); in_valid = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule